// File: doc/BRIEF.md
# Interrupt Post and Mask Front End

This block sits between a set of hardware interrupt sources and a downstream priority encoder. Each source owns a posted flag that a one-cycle hardware strobe sets, and a mask bit that decides whether that posted flag is forwarded as a pending request. The posted flags stay set until software clears them through a byte-wide register bus. The same bus holds the mask bits and one global control bit.

The control bit selects how writes to the posted-flag registers are read. When it is low, every written zero clears the matching flag and every written one is ignored. When it is high, every written one sets the matching flag as a software interrupt and every written zero is ignored. Software can therefore raise any interrupt without a hardware event, which helps when testing service routines. Reads return the registers one cycle after the read strobe and change nothing.

Top module: `irq_post_mask_ctrl`

## Requirements
- R1: After a synchronous active-high reset every posted flag, every mask bit and the mode bit are 0, `irq_pend` is all zeros and `bus_rdata` is 0.
- R2: A high `hw_evt[i]` in a cycle sets posted flag i at the next clock edge whatever the state of mask bit i. The flag then stays set until the bus clears it.
- R3: `irq_pend[i]` is 1 exactly when posted flag i and mask bit i are both 1.
- R4: The posted flags of group g (sources 8g..8g+7, bit b = source 8g+b) sit at address g, for g = 0..2. The mask bits of group g sit at address 4+g. A mask write sets each implemented mask bit of that group to the written bit and leaves every other mask bit unchanged.
- R5: With the mode bit at 0, a write to posted-flag address g clears the flags whose written bit is 0 and leaves the flags whose written bit is 1 unchanged.
- R6: With the mode bit at 1, a write to posted-flag address g sets the flags whose written bit is 1 and leaves the flags whose written bit is 0 unchanged.
- R7: The mode bit is bit 7 of the control register at address 7. Bits 6:0 of that register read 0. Addresses 3, 8 and above read 0.
- R8: Only the implemented source positions hold state. The defaults are 0xFE for group 0, 0xF0 for group 1 and 0x7B for group 2. Unimplemented positions ignore writes and hardware events and read 0, and they never raise `irq_pend`.
- R9: If a hardware event and a bus clear hit the same source in the same cycle, the posted flag ends up set.
- R10: A read returns the register value as it was before that clock edge, on `bus_rdata` one cycle after `bus_rd`. `bus_rdata` is 0 in a cycle after no read. A read changes no posted flag, mask bit or mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| hw_evt | input | 24 | One-cycle hardware event strobes, one per source |
| irq_pend | output | 24 | Pending requests to the priority encoder |

## Verification
Hardware strobes are applied to every source while all masks are closed. This separates posting from forwarding. The same clear-register write patterns, alternating and complementary nibbles, are then applied under both mode settings, so a polarity swap or a mode decoded from the wrong bit gives a different flag set. Clears that coincide with strobes on the same source check the event-wins rule. Writes and strobes on unimplemented positions show whether state leaks in there. A long stretch of mixed random bus traffic and strobes, compared each cycle against the behavioural model, covers interactions between groups and read timing.

// File: rtl/irq_pm_pkg.sv
package irq_pm_pkg;

    localparam int GRP_W     = 8;
    localparam int ADDR_W    = 4;
    localparam int CLR_BASE  = 0;
    localparam int MSK_BASE  = 4;
    localparam int CTRL_ADDR = 7;
    localparam int MODE_BIT  = 7;

    typedef logic [GRP_W-1:0]  byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        REG_POST = 2'd0,
        REG_MASK = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        addr_t     grp;
    } reg_sel_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_t sel;
        byte_t    data;
    } bus_req_t;

    function automatic reg_sel_t decode_addr(addr_t addr, int num_grp);
        reg_sel_t s;
        s.kind = REG_NONE;
        s.grp  = '0;
        if (int'(addr) >= CLR_BASE && int'(addr) < CLR_BASE + num_grp) begin
            s.kind = REG_POST;
            s.grp  = addr - addr_t'(CLR_BASE);
        end else if (int'(addr) >= MSK_BASE && int'(addr) < MSK_BASE + num_grp) begin
            s.kind = REG_MASK;
            s.grp  = addr - addr_t'(MSK_BASE);
        end else if (int'(addr) == CTRL_ADDR) begin
            s.kind = REG_CTRL;
        end
        return s;
    endfunction

    // Polarity-dependent interpretation of a write to a posted-flag register.
    function automatic byte_t apply_post_write(byte_t cur, byte_t wdata, logic sw_mode);
        return sw_mode ? (cur | wdata) : (cur & wdata);
    endfunction

endpackage

// File: rtl/irq_pm_decode.sv
module irq_pm_decode
    import irq_pm_pkg::*;
#(
    parameter int NUM_GRP = 3
) (
    input  addr_t                bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  byte_t                bus_wdata,
    output bus_req_t             req,
    output logic [NUM_GRP-1:0]   post_we,
    output logic [NUM_GRP-1:0]   mask_we,
    output logic                 ctrl_we
);

    always_comb begin
        req.wr   = bus_wr;
        req.rd   = bus_rd;
        req.sel  = decode_addr(bus_addr, NUM_GRP);
        req.data = bus_wdata;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_we
        assign post_we[g] = req.wr && (req.sel.kind == REG_POST) && (int'(req.sel.grp) == g);
        assign mask_we[g] = req.wr && (req.sel.kind == REG_MASK) && (int'(req.sel.grp) == g);
    end

    assign ctrl_we = req.wr && (req.sel.kind == REG_CTRL);

endmodule

// File: rtl/irq_pm_post_bank.sv
module irq_pm_post_bank
    import irq_pm_pkg::*;
#(
    parameter int                     NUM_GRP = 3,
    parameter logic [NUM_GRP*8-1:0]   IMPL    = '1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_GRP-1:0]       post_we,
    input  byte_t                    wdata,
    input  logic                     sw_mode,
    input  logic [NUM_GRP*8-1:0]     hw_evt,
    output logic [NUM_GRP*8-1:0]     posted_q
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam byte_t IMPL_G = IMPL[g*GRP_W +: GRP_W];
        byte_t cur_q;
        byte_t nxt;

        always_comb begin
            nxt = cur_q;
            if (post_we[g]) begin
                nxt = apply_post_write(cur_q, wdata, sw_mode);
            end
            // Hardware strobes win over a same-cycle clear.
            nxt = (nxt | hw_evt[g*GRP_W +: GRP_W]) & IMPL_G;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q <= '0;
            end else begin
                cur_q <= nxt;
            end
        end

        assign posted_q[g*GRP_W +: GRP_W] = cur_q;
    end

endmodule

// File: rtl/irq_pm_mask_bank.sv
module irq_pm_mask_bank
    import irq_pm_pkg::*;
#(
    parameter int                     NUM_GRP = 3,
    parameter logic [NUM_GRP*8-1:0]   IMPL    = '1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_GRP-1:0]       mask_we,
    input  logic                     ctrl_we,
    input  byte_t                    wdata,
    output logic [NUM_GRP*8-1:0]     mask_q,
    output logic                     sw_mode
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam byte_t IMPL_G = IMPL[g*GRP_W +: GRP_W];
        byte_t m_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= '0;
            end else if (mask_we[g]) begin
                m_q <= wdata & IMPL_G;
            end
        end

        assign mask_q[g*GRP_W +: GRP_W] = m_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_mode <= 1'b0;
        end else if (ctrl_we) begin
            sw_mode <= wdata[MODE_BIT];
        end
    end

endmodule

// File: rtl/irq_pm_read_mux.sv
module irq_pm_read_mux
    import irq_pm_pkg::*;
#(
    parameter int NUM_GRP = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_req_t               req,
    input  logic [NUM_GRP*8-1:0]   posted_q,
    input  logic [NUM_GRP*8-1:0]   mask_q,
    input  logic                   sw_mode,
    output byte_t                  rdata
);

    byte_t post_sel;
    byte_t mask_sel;
    byte_t val;

    always_comb begin
        post_sel = '0;
        mask_sel = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (int'(req.sel.grp) == g) begin
                post_sel = posted_q[g*GRP_W +: GRP_W];
                mask_sel = mask_q[g*GRP_W +: GRP_W];
            end
        end
    end

    always_comb begin
        unique case (req.sel.kind)
            REG_POST: val = post_sel;
            REG_MASK: val = mask_sel;
            REG_CTRL: val = byte_t'(sw_mode) << MODE_BIT;
            default:  val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= req.rd ? val : '0;
        end
    end

endmodule

// File: rtl/irq_post_mask_ctrl.sv
module irq_post_mask_ctrl
    import irq_pm_pkg::*;
#(
    parameter int                     NUM_GRP = 3,
    parameter logic [NUM_GRP*8-1:0]   IMPL    = 24'h7BF0FE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_GRP*8-1:0]    hw_evt,
    output logic [NUM_GRP*8-1:0]    irq_pend
);

    localparam int NSRC = NUM_GRP * GRP_W;

    bus_req_t           req;
    logic [NUM_GRP-1:0] post_we;
    logic [NUM_GRP-1:0] mask_we;
    logic               ctrl_we;
    logic [NSRC-1:0]    posted_q;
    logic [NSRC-1:0]    mask_q;
    logic               sw_mode;

    irq_pm_decode #(.NUM_GRP(NUM_GRP)) i_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .req       (req),
        .post_we   (post_we),
        .mask_we   (mask_we),
        .ctrl_we   (ctrl_we)
    );

    irq_pm_post_bank #(.NUM_GRP(NUM_GRP), .IMPL(IMPL)) i_post (
        .clk      (clk),
        .rst      (rst),
        .post_we  (post_we),
        .wdata    (req.data),
        .sw_mode  (sw_mode),
        .hw_evt   (hw_evt),
        .posted_q (posted_q)
    );

    irq_pm_mask_bank #(.NUM_GRP(NUM_GRP), .IMPL(IMPL)) i_mask (
        .clk     (clk),
        .rst     (rst),
        .mask_we (mask_we),
        .ctrl_we (ctrl_we),
        .wdata   (req.data),
        .mask_q  (mask_q),
        .sw_mode (sw_mode)
    );

    irq_pm_read_mux #(.NUM_GRP(NUM_GRP)) i_rd (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .posted_q (posted_q),
        .mask_q   (mask_q),
        .sw_mode  (sw_mode),
        .rdata    (bus_rdata)
    );

    assign irq_pend = posted_q & mask_q;

endmodule

// File: rtl/irq_post_mask_chk.sv
module irq_post_mask_chk #(
    parameter int                     NUM_GRP = 3,
    parameter logic [NUM_GRP*8-1:0]   IMPL    = '1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [3:0]              bus_addr,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [7:0]              bus_rdata,
    input logic [NUM_GRP*8-1:0]    hw_evt,
    input logic [NUM_GRP*8-1:0]    irq_pend,
    input logic [NUM_GRP*8-1:0]    posted_q,
    input logic [NUM_GRP*8-1:0]    mask_q,
    input logic                    sw_mode
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (irq_pend == '0 && bus_rdata == 8'h00 && !sw_mode));

    assert_event_posts_R2: assert property (@(posedge clk) disable iff (rst)
        (|(hw_evt & IMPL)) |=> (($past(hw_evt) & IMPL & ~posted_q) == '0));

    assert_pend_needs_mask_R3: assert property (@(posedge clk) disable iff (rst)
        ((irq_pend & ~mask_q) == '0) && ((irq_pend & ~posted_q) == '0));

    assert_mode0_no_set_R5: assert property (@(posedge clk) disable iff (rst)
        (!sw_mode && hw_evt == '0) |=> ((posted_q & ~$past(posted_q)) == '0));

    assert_mode1_no_clear_R6: assert property (@(posedge clk) disable iff (rst)
        sw_mode |=> ((~posted_q & $past(posted_q)) == '0));

    assert_ctrl_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 4'd7) |=> (bus_rdata[6:0] == 7'd0));

    assert_reserved_idle_R8: assert property (@(posedge clk) disable iff (rst)
        ((posted_q | mask_q | irq_pend) & ~IMPL) == '0);

    assert_read_no_effect_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && hw_evt == '0) |=>
            ($stable(posted_q) && $stable(mask_q) && $stable(sw_mode)));

endmodule

bind irq_post_mask_ctrl irq_post_mask_chk #(.NUM_GRP(NUM_GRP), .IMPL(IMPL)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .hw_evt    (hw_evt),
    .irq_pend  (irq_pend),
    .posted_q  (posted_q),
    .mask_q    (mask_q),
    .sw_mode   (sw_mode)
);

// File: tb/test_irq_post_mask_ctrl.sv
module test_irq_post_mask_ctrl;

    localparam int          NSRC = 24;
    localparam logic [23:0] IMPL = 24'h7BF0FE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] hw_evt = '0;
    logic [23:0] irq_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state.
    bit          m_post [NSRC];
    bit          m_mask [NSRC];
    bit          m_mode;
    logic [7:0]  m_rd;

    always #10ns clk = ~clk;

    irq_post_mask_ctrl i_irq_post_mask_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_evt    (hw_evt),
        .irq_pend  (irq_pend)
    );

    function automatic logic [7:0] model_read(logic [3:0] a);
        logic [7:0] v = '0;
        if (a <= 4'd2) begin
            for (int b = 0; b < 8; b++) v[b] = m_post[int'(a)*8 + b];
        end else if (a >= 4'd4 && a <= 4'd6) begin
            for (int b = 0; b < 8; b++) v[b] = m_mask[(int'(a)-4)*8 + b];
        end else if (a == 4'd7) begin
            v[7] = m_mode;
        end
        return v;
    endfunction

    function automatic logic [23:0] model_pend();
        logic [23:0] p = '0;
        for (int i = 0; i < NSRC; i++) p[i] = m_post[i] & m_mask[i];
        return p;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NSRC; i++) begin
            m_post[i] = 1'b0;
            m_mask[i] = 1'b0;
        end
        m_mode = 1'b0;
        m_rd   = '0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: drive, let the edge pass, update the model, compare.
    task automatic cyc(input logic [3:0] a, input logic w, input logic r,
                       input logic [7:0] d, input logic [23:0] e, input string req);
        bit new_mode;
        bus_addr  = a;
        bus_wr    = w;
        bus_rd    = r;
        bus_wdata = d;
        hw_evt    = e;
        @(posedge clk);
        m_rd     = r ? model_read(a) : 8'h00;
        new_mode = m_mode;
        for (int i = 0; i < NSRC; i++) begin
            int g = i / 8;
            int b = i % 8;
            if (IMPL[i]) begin
                if (e[i]) begin
                    m_post[i] = 1'b1;
                end else if (w && int'(a) == g) begin
                    if (m_mode && d[b])        m_post[i] = 1'b1;
                    else if (!m_mode && !d[b]) m_post[i] = 1'b0;
                end
                if (w && int'(a) == 4 + g) m_mask[i] = d[b];
            end
        end
        if (w && a == 4'd7) new_mode = d[7];
        m_mode = new_mode;
        @(negedge clk);
        check({req, " pend"}, 32'(irq_pend), 32'(model_pend()));
        check({req, " rdata"}, 32'(bus_rdata), 32'(m_rd));
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
        cyc(a, 1'b1, 1'b0, d, '0, req);
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        cyc(a, 1'b0, 1'b1, 8'h00, '0, req);
    endtask

    initial begin
        #(200000 * 20ns);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports.
        check("R1 pend after reset", 32'(irq_pend), 32'h0);
        check("R1 rdata after reset", 32'(bus_rdata), 32'h0);
        for (int a = 0; a < 16; a++) rd(4'(a), "R1 R7 read after reset");
        cyc(4'd0, 1'b0, 1'b0, 8'h00, '0, "R10 rdata idle");

        // R2 R8: events on every source with masks closed.
        cyc(4'd0, 1'b0, 1'b0, 8'h00, 24'hFFFFFF, "R2 events masked");
        rd(4'd0, "R2 R8 posted group0");
        rd(4'd1, "R2 R8 posted group1");
        rd(4'd2, "R2 R8 posted group2");

        // R3 R4: independent mask bits per group.
        wr(4'd4, 8'hA5, "R4 mask group0");
        rd(4'd4, "R4 mask readback");
        wr(4'd5, 8'h3C, "R4 mask group1");
        wr(4'd6, 8'hFF, "R3 mask group2");
        rd(4'd5, "R4 mask group1 readback");
        rd(4'd4, "R4 group0 untouched");

        // R5: mode 0 clears on zeros, ignores ones.
        wr(4'd0, 8'hF0, "R5 clear low nibble");
        rd(4'd0, "R5 readback");
        wr(4'd1, 8'hFF, "R5 ones ignored");
        wr(4'd2, 8'h55, "R5 alternating clear");
        rd(4'd2, "R5 readback group2");

        // R7: mode bit at bit 7 of address 7.
        wr(4'd7, 8'h7F, "R7 low bits do not set mode");
        rd(4'd7, "R7 mode still clear");
        wr(4'd7, 8'hFF, "R7 enable mode");
        rd(4'd7, "R7 reads 0x80");

        // R6: mode 1 sets on ones, ignores zeros.
        wr(4'd0, 8'h0F, "R6 set low nibble");
        rd(4'd0, "R6 readback");
        wr(4'd2, 8'h00, "R6 zeros ignored");
        wr(4'd2, 8'hAA, "R6 alternating set");
        rd(4'd2, "R6 readback group2");

        // R8: reserved positions ignore software set and hardware events.
        wr(4'd1, 8'h0F, "R8 reserved software set");
        cyc(4'd0, 1'b0, 1'b0, 8'h00, 24'h840F01, "R8 reserved events");
        rd(4'd1, "R8 reserved readback");
        rd(4'd3, "R7 hole reads zero");

        // R9: event wins over same-cycle clear in mode 0.
        wr(4'd7, 8'h00, "R7 disable mode");
        cyc(4'd1, 1'b1, 1'b0, 8'h00, 24'h00_1000, "R9 clear with event");
        rd(4'd1, "R9 readback");
        cyc(4'd2, 1'b1, 1'b0, 8'h00, 24'h01_0000, "R9 clear with event group2");
        rd(4'd2, "R9 readback group2");

        // R10: back-to-back reads.
        rd(4'd4, "R10 read a");
        rd(4'd5, "R10 read b");
        cyc(4'd0, 1'b0, 1'b0, 8'h00, '0, "R10 idle after read");

        // Mixed traffic.
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  a = 4'($urandom_range(0, 8));
            logic        w = 1'($urandom);
            logic        r = 1'($urandom);
            logic [7:0]  d = 8'($urandom);
            logic [23:0] e = ($urandom_range(0, 3) == 0) ? 24'($urandom) : 24'h0;
            cyc(a, w, r, d, e, "R3 R5 R6 R9 mixed");
        end

        // R1: reset again from a busy state.
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        check("R1 pend after second reset", 32'(irq_pend), 32'h0);
        rd(4'd7, "R1 mode after second reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule